// File: doc/BRIEF.md
# Parallel NOR Flash Command Front-End

This block models the control side of a byte-wide parallel NOR flash as a synchronous, clocked design. The three active-low bus strobes (chip enable, output enable and write enable) are sampled on every clock. Each strobe pattern is classed as a read cycle, a write cycle or idle. Write cycles feed a small command state machine. An unlock prefix followed by a command byte either enters an identification mode or arms a single-byte program. Program bytes go into a small internal register file that starts erased (all ones). A program can only clear bits.

While a program runs, the ready output is low and reads return a status byte in place of array data. A separate active-low reset pin floats the data bus and blocks all bus cycles for as long as it is low. If it stays low long enough, it drops the block back to array reading and abandons any program in flight. An abandoned program holds ready low for a fixed recovery window.

Top module: `nor_cmd_front`

## Requirements
- R1: After power-on reset the block is in array-read mode. A read cycle (ce_n=0, oe_n=0, we_n=1) drives dout with the array byte at index addr[IDX_W-1:0], with dout_en=1, in the same cycle. Every array byte reads 0xFF after power-on reset.
- R2: dout_en is 0 whenever oe_n=1 or ce_n=1 or we_n=0.
- R3: A write cycle is ce_n=0, we_n=0, oe_n=1. Its address and data are taken once, on the first clock edge at which the pattern is seen, however many cycles it is held.
- R4: Three writes enter identification mode: 0xAA to address 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555. In that mode, reads at address 0 return MFR_ID (default 0x5A), reads at address 1 return DEV_ID (default 0xB4), and reads at any other address return 0x00.
- R5: A write during the unlock sequence whose address or data does not match the expected step returns the block to array-read mode.
- R6: Writing 0xF0 during an unlock step, or while in identification mode, returns the block to array-read mode.
- R7: The unlock prefix followed by 0xA0 to 0x555 arms a program. The next write programs array index addr[IDX_W-1:0]. The new byte is the old byte AND the written data.
- R8: ready goes low on the edge that takes the program data and stays low for exactly PGM_CYC clock edges. Writes that arrive while ready is low are ignored.
- R9: While ready is low, reads return a status byte. Its bit 7 is the inverse of bit 7 of the byte being programmed, and bits 6..0 are zero.
- R10: While rst_pin_n=0, dout_en is 0 and write cycles are ignored, however short the pulse.
- R11: Holding rst_pin_n low for RST_MIN consecutive clock edges returns the block to array-read mode. A shorter pulse leaves the mode unchanged.
- R12: If the R11 abort hits while ready is low, the pending program is not applied. ready stays low for exactly RECOV clock edges after the abort edge, then goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Data bus drive enable; 0 means tristated |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
Read data and dout_en are combinational, so the bench applies a read pattern just after a falling clock edge and samples 1 ns later, with no clock edge in between. A write takes effect on the rising edge that first sees it, so mode-dependent reads are checked at the next falling edge. ready is checked by counting falling edges from the capture edge: it must still be low after PGM_CYC-1 edges and high after PGM_CYC. Abort timing is checked the same way, counting RST_MIN edges of low reset pin and then RECOV edges of recovery.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    S_READ, S_UNLK1, S_UNLK2, S_AUTO, S_ARMED, S_BUSY, S_RECOV
  } fsm_e;

  localparam logic [15:0] ADR_KEY_A = 16'h0555;
  localparam logic [15:0] ADR_KEY_B = 16'h02AA;
  localparam logic [7:0]  DAT_KEY_A = 8'hAA;
  localparam logic [7:0]  DAT_KEY_B = 8'h55;
  localparam logic [7:0]  OP_IDENT  = 8'h90;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_EXIT   = 8'hF0;

  function automatic logic cmd_hit(input logic [15:0] a, input logic [7:0] d,
                                   input logic [15:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic fsm_e cmd_next(input fsm_e st, input logic [15:0] a,
                                    input logic [7:0] d);
    fsm_e n;
    n = S_READ;
    case (st)
      S_READ:  n = cmd_hit(a, d, ADR_KEY_A, DAT_KEY_A) ? S_UNLK1 : S_READ;
      S_UNLK1: n = cmd_hit(a, d, ADR_KEY_B, DAT_KEY_B) ? S_UNLK2 : S_READ;
      S_UNLK2: begin
        if (cmd_hit(a, d, ADR_KEY_A, OP_IDENT))      n = S_AUTO;
        else if (cmd_hit(a, d, ADR_KEY_A, OP_PROG))  n = S_ARMED;
        else                                         n = S_READ;
      end
      S_AUTO:  n = (d == OP_EXIT) ? S_READ : S_AUTO;
      S_ARMED: n = S_BUSY;
      default: n = st;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(input logic [7:0] pend);
    return {~pend[7], 7'b0};
  endfunction

  function automatic logic [7:0] ident_byte(input logic [15:0] a, input logic [7:0] mfr,
                                            input logic [7:0] dev);
    if (a == 16'd0) return mfr;
    if (a == 16'd1) return dev;
    return 8'h00;
  endfunction

endpackage

// File: rtl/nfc_strobe_decode.sv
module nfc_strobe_decode (
  input  logic clk,
  input  logic por_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic pin_ok,
  output logic rd_cycle,
  output logic wr_pulse
);
  logic wr_cond, wr_seen_q;

  assign rd_cycle = !ce_n && !oe_n && we_n && pin_ok;
  assign wr_cond  = !ce_n && !we_n && oe_n;
  assign wr_pulse = wr_cond && !wr_seen_q && pin_ok;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wr_seen_q <= 1'b0;
    else        wr_seen_q <= wr_cond;
  end

  a_r3_single_capture: assert property (@(posedge clk) disable iff (!por_n)
    wr_pulse |=> !wr_pulse);
  a_r10_no_write_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    !pin_ok |-> !wr_pulse);
endmodule

// File: rtl/nfc_rst_filter.sv
module nfc_rst_filter #(
  parameter int RST_MIN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_ok,
  output logic abort
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);
  logic [CW-1:0] low_cnt;

  assign pin_ok = pin_n;
  assign abort  = !pin_n && (low_cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   low_cnt <= '0;
    else if (pin_n)               low_cnt <= '0;
    else if (low_cnt != LAST + 1'b1) low_cnt <= low_cnt + 1'b1;
  end

  a_r11_abort_once: assert property (@(posedge clk) disable iff (!por_n)
    abort |=> !abort);

  generate
    if (RST_MIN > 1) begin : g_width
      a_r11_width: assert property (@(posedge clk) disable iff (!por_n)
        abort |-> ($past(low_cnt) == LAST - 1'b1));
    end
  endgenerate
endmodule

// File: rtl/nfc_byte_array.sv
module nfc_byte_array #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);
  import nfc_pkg::*;
  logic [7:0] mem [DEPTH];
  logic [7:0] wr_old;

  assign rdata  = mem[ridx];
  assign wr_old = mem[widx];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[widx] <= prog_merge(wr_old, wdata);
    end
  end

  a_r7_clear_only: assert property (@(posedge clk) disable iff (!por_n)
    we |=> ((mem[$past(widx)] & ~$past(wr_old)) == 8'h00));
endmodule

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm #(
  parameter int AW      = 11,
  parameter int IW      = 4,
  parameter int PGM_CYC = 8,
  parameter int RECOV   = 6
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_pulse,
  input  logic          abort,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output nfc_pkg::fsm_e st,
  output logic          ready,
  output logic          mem_we,
  output logic [IW-1:0] mem_idx,
  output logic [7:0]    pend_data
);
  import nfc_pkg::*;
  localparam int MAXC = (PGM_CYC > RECOV) ? PGM_CYC : RECOV;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic [15:0]   a16;
  logic          busy_st, cnt_last;

  assign a16      = 16'(addr);
  assign busy_st  = (st == S_BUSY) || (st == S_RECOV);
  assign ready    = !busy_st;
  assign cnt_last = (cnt == ONE);
  assign mem_we   = (st == S_BUSY) && cnt_last && !abort;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_READ;
      cnt       <= '0;
      mem_idx   <= '0;
      pend_data <= '0;
    end else if (abort) begin
      if (busy_st) begin
        st  <= S_RECOV;
        cnt <= CW'(RECOV);
      end else begin
        st  <= S_READ;
      end
    end else if (busy_st) begin
      if (cnt_last) st <= S_READ;
      else          cnt <= cnt - ONE;
    end else if (wr_pulse) begin
      st <= cmd_next(st, a16, din);
      if (st == S_ARMED) begin
        cnt       <= CW'(PGM_CYC);
        mem_idx   <= addr[IW-1:0];
        pend_data <= din;
      end
    end
  end

  a_r8_busy_on_capture: assert property (@(posedge clk) disable iff (!por_n)
    (wr_pulse && st == S_ARMED && !abort) |=> !ready);
  a_r8_ready_rise: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> ($past(cnt) == ONE));
  a_r8_ignore_busy_writes: assert property (@(posedge clk) disable iff (!por_n)
    (!ready && !abort && !cnt_last) |=> (!ready && $stable(pend_data)));
  a_r12_abort_keeps_busy: assert property (@(posedge clk) disable iff (!por_n)
    (abort && !ready) |=> (!ready && !mem_we));
  a_r11_abort_to_read: assert property (@(posedge clk) disable iff (!por_n)
    (abort && ready) |=> (st == S_READ));
endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front #(
  parameter int AW          = 11,
  parameter int DEPTH       = 16,
  parameter int PGM_CYC     = 8,
  parameter int RECOV       = 6,
  parameter int RST_MIN     = 4,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hB4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_pin_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          ready
);
  import nfc_pkg::*;
  localparam int IW = $clog2(DEPTH);

  logic          pin_ok, abort, rd_cycle, wr_pulse, mem_we;
  logic [IW-1:0] mem_idx;
  logic [7:0]    pend_data, arr_byte;
  fsm_e          st;

  nfc_rst_filter #(.RST_MIN(RST_MIN)) u_filt (
    .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .pin_ok(pin_ok), .abort(abort));

  nfc_strobe_decode u_strb (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pin_ok(pin_ok), .rd_cycle(rd_cycle), .wr_pulse(wr_pulse));

  nfc_cmd_fsm #(.AW(AW), .IW(IW), .PGM_CYC(PGM_CYC), .RECOV(RECOV)) u_fsm (
    .clk(clk), .por_n(por_n), .wr_pulse(wr_pulse), .abort(abort), .addr(addr),
    .din(din), .st(st), .ready(ready), .mem_we(mem_we), .mem_idx(mem_idx),
    .pend_data(pend_data));

  nfc_byte_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .por_n(por_n), .we(mem_we), .widx(mem_idx), .wdata(pend_data),
    .ridx(addr[IW-1:0]), .rdata(arr_byte));

  assign dout_en = rd_cycle;

  always_comb begin
    if (!ready)             dout = status_byte(pend_data);
    else if (st == S_AUTO)  dout = ident_byte(16'(addr), MFR_ID, DEV_ID);
    else                    dout = arr_byte;
  end

  a_r2_output_float: assert property (@(posedge clk) disable iff (!por_n)
    (oe_n || ce_n || !we_n) |-> !dout_en);
  a_r10_pin_floats_bus: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pin_n |-> !dout_en);
  a_r9_status_when_busy: assert property (@(posedge clk) disable iff (!por_n)
    (!ready && dout_en) |-> (dout[6:0] == 7'h00));
endmodule

// File: tb/nor_cmd_front_bench.sv
module nor_cmd_front_bench;
  localparam int AW = 11, DEPTH = 16, PGM_CYC = 8, RECOV = 6, RST_MIN = 4;
  localparam logic [7:0] MFR = 8'h5A, DEV = 8'hB4;

  logic clk = 1'b0, por_n = 1'b0, rst_pin_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en, ready;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] rv;
  logic       re;

  always #4 clk = ~clk;

  nor_cmd_front #(.AW(AW), .DEPTH(DEPTH), .PGM_CYC(PGM_CYC), .RECOV(RECOV),
                  .RST_MIN(RST_MIN), .MFR_ID(MFR), .DEV_ID(DEV)) u_nor_cmd_front (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready));

  function automatic logic [7:0] exp_stat(input logic [7:0] d);
    return d[7] ? 8'h00 : 8'h80;
  endfunction

  function automatic logic [7:0] exp_and(input logic [7:0] o, input logic [7:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = o[b] ? d[b] : 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1; rv = dout; re = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    #1;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state and default read
    chk("R1 ready after reset", {8'h0, ready}, 9'h1);
    rd(11'd3); chk("R1 erased read", {re, rv}, {1'b1, 8'hFF});
    // R2 bus float
    ce_n = 1'b0; oe_n = 1'b1; #1; chk("R2 oe high", {8'h0, dout_en}, 9'h0);
    ce_n = 1'b1; oe_n = 1'b0; #1; chk("R2 ce high", {8'h0, dout_en}, 9'h0);
    ce_n = 1'b0; we_n = 1'b0; #1; chk("R2 we low", {8'h0, dout_en}, 9'h0);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

    // R4 identification mode
    unlock(); wr(11'h555, 8'h90);
    @(negedge clk);
    rd(11'd0); chk("R4 mfr", {re, rv}, {1'b1, MFR});
    rd(11'd1); chk("R4 dev", {re, rv}, {1'b1, DEV});
    rd(11'd2); chk("R4 other", {re, rv}, {1'b1, 8'h00});
    wr(11'h123, 8'h00); @(negedge clk);
    rd(11'd0); chk("R4 stays in ident", {re, rv}, {1'b1, MFR});
    // R6 exit from ident
    wr(11'h7FF, 8'hF0); @(negedge clk);
    rd(11'd0); chk("R6 exit ident", {re, rv}, {1'b1, 8'hFF});

    // R5 wrong data and wrong address
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h54); wr(11'h555, 8'h90); @(negedge clk);
    rd(11'd1); chk("R5 bad data", {re, rv}, {1'b1, 8'hFF});
    unlock(); wr(11'h554, 8'h90); @(negedge clk);
    rd(11'd1); chk("R5 bad addr", {re, rv}, {1'b1, 8'hFF});
    wr(11'h2AA, 8'h55); wr(11'h555, 8'hAA); wr(11'h555, 8'h90); @(negedge clk);
    rd(11'd1); chk("R5 bad order", {re, rv}, {1'b1, 8'hFF});
    // R6 exit at an unlock step
    wr(11'h555, 8'hAA); wr(11'h555, 8'hF0); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
    @(negedge clk);
    rd(11'd1); chk("R6 exit at step", {re, rv}, {1'b1, 8'hFF});

    // R3 long write counts once
    wr(11'h555, 8'hAA, 4); wr(11'h2AA, 8'h55, 3); wr(11'h555, 8'h90, 2);
    @(negedge clk);
    rd(11'd1); chk("R3 held write once", {re, rv}, {1'b1, DEV});
    wr(11'h0, 8'hF0);

    // R7 R8 R9 exact program timing
    unlock(); wr(11'h555, 8'hA0);
    @(negedge clk);
    addr = 11'd6; din = 8'h3C; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    chk("R8 busy after capture", {8'h0, ready}, 9'h0);
    rd(11'd6); chk("R9 status", {re, rv}, {1'b1, exp_stat(8'h3C)});
    repeat (PGM_CYC - 1) @(negedge clk);
    chk("R8 still busy", {8'h0, ready}, 9'h0);
    @(negedge clk);
    chk("R8 ready on time", {8'h0, ready}, 9'h1);
    mdl[6] = exp_and(mdl[6], 8'h3C);
    rd(11'd6); chk("R7 programmed", {re, rv}, {1'b1, mdl[6]});

    // R8 writes ignored while busy, R9 with bit 7 set
    unlock(); wr(11'h555, 8'hA0); wr(11'd6, 8'hF5);
    rd(11'd9); chk("R9 status b7", {re, rv}, {1'b1, exp_stat(8'hF5)});
    unlock(); wr(11'h555, 8'h90);
    for (int k = 0; k < 20 && !ready; k++) @(negedge clk);
    mdl[6] = exp_and(mdl[6], 8'hF5);
    rd(11'd1); chk("R8 busy writes ignored", {re, rv}, {1'b1, mdl[1]});
    rd(11'd6); chk("R7 and merge", {re, rv}, {1'b1, mdl[6]});

    // R7 random programs
    for (int it = 0; it < 40; it++) begin
      logic [3:0] ix;
      logic [7:0] dv;
      ix = 4'($urandom); dv = 8'($urandom) | 8'($urandom);
      unlock(); wr(11'h555, 8'hA0); wr({7'($urandom), ix}, dv);
      for (int k = 0; k < 20 && !ready; k++) @(negedge clk);
      mdl[ix] = exp_and(mdl[ix], dv);
    end
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i)); chk("R7 random sweep", {re, rv}, {1'b1, mdl[i]});
    end

    // R10 pin low floats bus and blocks writes
    @(negedge clk); rst_pin_n = 1'b0;
    rd(11'd0); chk("R10 bus floated", {8'h0, re}, 9'h0);
    rst_pin_n = 1'b1;
    rst_pin_n = 1'b0; wr(11'h555, 8'hAA); rst_pin_n = 1'b1;
    wr(11'h2AA, 8'h55); wr(11'h555, 8'h90); @(negedge clk);
    rd(11'd1); chk("R10 write ignored", {re, rv}, {1'b1, mdl[1]});

    // R11 short pulse keeps mode, full pulse aborts
    unlock(); wr(11'h555, 8'h90); @(negedge clk);
    rst_pin_n = 1'b0; repeat (RST_MIN - 1) @(negedge clk); rst_pin_n = 1'b1;
    @(negedge clk);
    rd(11'd0); chk("R11 short pulse", {re, rv}, {1'b1, MFR});
    rst_pin_n = 1'b0; repeat (RST_MIN) @(negedge clk); rst_pin_n = 1'b1;
    @(negedge clk);
    rd(11'd0); chk("R11 full pulse", {re, rv}, {1'b1, mdl[0]});

    // R12 abort during program
    unlock(); wr(11'h555, 8'hA0); wr(11'd5, 8'h00);
    rst_pin_n = 1'b0;
    repeat (RST_MIN) @(negedge clk);
    chk("R12 busy at abort", {8'h0, ready}, 9'h0);
    rst_pin_n = 1'b1;
    repeat (RECOV - 1) @(negedge clk);
    chk("R12 recovery holds", {8'h0, ready}, 9'h0);
    @(negedge clk);
    chk("R12 ready after recovery", {8'h0, ready}, 9'h1);
    rd(11'd5); chk("R12 program dropped", {re, rv}, {1'b1, mdl[5]});

    finish_run();
  end
endmodule